// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block is the fetch side of a bus interface unit. It keeps a small first-in, first-out queue of instruction bytes ahead of an execution unit so that the execution side rarely waits for memory. Bytes come from a 16-bit memory port. A fetch from an even address brings in a whole word, and a fetch from an odd address brings in one byte. A new prefetch starts only when the queue has room for two more bytes and the execution side is not asking for an operand cycle.

The execution side takes bytes one per cycle. For each byte it says whether that byte opens a new opcode, and a 2-bit status code reports every take and every flush. A branch is a single-cycle flush with a new target address. The flush empties the queue and restarts fetching from the target. If a fetch was already under way when the flush came, the memory handshake still completes, but the returned data is thrown away.

Top module: `ifq_ctrl`

## Requirements
- R1: The queue holds up to 6 bytes and hands them out in strict address order, starting at the last flush target. `byte_o` shows the oldest byte whenever `byte_vld_o` is 1.
- R2: A prefetch is launched (`mem_req_o` rises on the next cycle) only when at least 2 of the 6 slots are free and `opnd_req_i` is low. With 5 or 6 bytes held, no fetch starts.
- R3: A fetch from an even address has `mem_two_o`=1 and loads `mem_rdata_i[7:0]` and then `mem_rdata_i[15:8]`. A fetch from an odd address has `mem_two_o`=0 and loads only `mem_rdata_i[15:8]`.
- R4: While a fetch is in flight, `opnd_gnt_o` stays 0 until the cycle after its `mem_ack_i`. With no fetch in flight, `opnd_gnt_o` follows `opnd_req_i`. A high `opnd_req_i` blocks any new launch.
- R5: A flush empties the queue by the next cycle. It wins over a pop in the same cycle and over data acknowledged in or after that cycle for a fetch launched before it. That data is discarded.
- R6: A pop on an empty queue takes nothing and reports status 00. The pop stays pending until a byte arrives.
- R7: `qs_o` is 10 in a flush cycle. Otherwise it is 01 for a take with `pop_first_i`=1, 11 for a take with `pop_first_i`=0, and 00 when nothing is taken.
- R8: The fetch address advances by the number of bytes actually loaded (1 after an odd address, 2 after an even one), so a stream that starts odd continues word-aligned. A flush reloads it from `flush_addr_i`.
- R9: `mem_req_o` and `mem_addr_o` hold steady until the cycle in which `mem_ack_i` is 1. `mem_req_o` is low in the cycle after the acknowledge.
- R10: After reset the queue is empty, `qs_o` is 00, no request is pending, and the first fetch goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Single-cycle branch/flush command |
| flush_addr_i | input | AW | New fetch address for a flush |
| pop_i | input | 1 | Execution side takes the head byte |
| pop_first_i | input | 1 | The byte being taken opens an opcode |
| opnd_req_i | input | 1 | Operand read/write cycle wanted |
| opnd_gnt_o | output | 1 | Operand cycle may use the memory port |
| mem_req_o | output | 1 | Fetch request, held until acknowledge |
| mem_addr_o | output | AW | Fetch address |
| mem_two_o | output | 1 | Fetch is a full word (even address) |
| mem_ack_i | input | 1 | Memory returns data this cycle |
| mem_rdata_i | input | 16 | Returned word |
| byte_o | output | 8 | Head byte of the queue |
| byte_vld_o | output | 1 | Queue is not empty |
| qs_o | output | 2 | Queue status code |

## Verification
Wrong pointer or count state shows up on the first pop that follows it. In that same cycle, `byte_o` differs from the byte computed from the address stream, or `byte_vld_o` disagrees with the fill level implied by the fetches seen so far. A wrong room calculation shows one or two cycles later, either as a `mem_req_o` while the queue holds five or six bytes or as a fetch that never starts after two pops. A stale fetch that is not discarded corrupts the first byte taken after the flush. A wrongly advanced fetch address is visible on `mem_addr_o` at the next request.

// File: rtl/ifq_pkg.sv
package ifq_pkg;
    typedef enum logic [1:0] {
        QS_IDLE    = 2'b00,
        QS_FIRST   = 2'b01,
        QS_FLUSHED = 2'b10,
        QS_NEXT    = 2'b11
    } qs_e;
endpackage

// File: rtl/ifq_store.sv
module ifq_store #(
    parameter int DEPTH = 6,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          pop_i,
    input  logic [1:0]    push_n_i,
    input  logic [7:0]    push_b0_i,
    input  logic [7:0]    push_b1_i,
    output logic [7:0]    head_o,
    output logic [CW-1:0] count_o
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PW-1:0]         rd;
        logic [PW-1:0]         wr;
        logic [CW-1:0]         cnt;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] p, input logic [1:0] inc);
        logic [PW:0] s;
        s = {1'b0, p} + (PW+1)'(inc);
        if (s >= (PW+1)'(DEPTH)) s = s - (PW+1)'(DEPTH);
        return s[PW-1:0];
    endfunction

    always_comb begin
        logic taken;
        st_d  = st_q;
        taken = pop_i && (st_q.cnt != '0);
        if (clear_i) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (taken) st_d.rd = wrap_add(st_q.rd, 2'd1);
            if (push_n_i != 2'd0) st_d.mem[st_q.wr] = push_b0_i;
            if (push_n_i == 2'd2) st_d.mem[wrap_add(st_q.wr, 2'd1)] = push_b1_i;
            st_d.wr  = wrap_add(st_q.wr, push_n_i);
            st_d.cnt = st_q.cnt - CW'(taken) + CW'(push_n_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rd];
    assign count_o = st_q.cnt;
endmodule

// File: rtl/ifq_fetch.sv
module ifq_fetch #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [AW-1:0] flush_addr_i,
    input  logic          launch_ok_i,
    input  logic          mem_ack_i,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_two_o,
    output logic          deliver_o,
    output logic [1:0]    deliver_n_o
);
    typedef struct packed {
        logic          busy;
        logic          stale;
        logic [AW-1:0] req_addr;
        logic [AW-1:0] fetch_addr;
    } st_t;

    st_t st_d, st_q;
    logic       done;
    logic [1:0] nbytes;

    assign nbytes    = st_q.req_addr[0] ? 2'd1 : 2'd2;
    assign done      = st_q.busy && mem_ack_i;
    assign deliver_o = done && !st_q.stale && !flush_i;

    always_comb begin
        st_d = st_q;
        if (done) begin
            st_d.busy  = 1'b0;
            st_d.stale = 1'b0;
            if (deliver_o) st_d.fetch_addr = st_q.fetch_addr + AW'(nbytes);
        end
        if (flush_i) begin
            st_d.fetch_addr = flush_addr_i;
            if (st_q.busy && !mem_ack_i) st_d.stale = 1'b1;
        end else if (!st_q.busy && launch_ok_i) begin
            st_d.busy     = 1'b1;
            st_d.stale    = 1'b0;
            st_d.req_addr = st_q.fetch_addr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_req_o   = st_q.busy;
    assign mem_addr_o  = st_q.req_addr;
    assign mem_two_o   = !st_q.req_addr[0];
    assign deliver_n_o = deliver_o ? nbytes : 2'd0;
endmodule

// File: rtl/ifq_ctrl.sv
module ifq_ctrl #(
    parameter int DEPTH = 6,
    parameter int AW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [AW-1:0] flush_addr_i,
    input  logic          pop_i,
    input  logic          pop_first_i,
    input  logic          opnd_req_i,
    output logic          opnd_gnt_o,
    output logic          mem_req_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_two_o,
    input  logic          mem_ack_i,
    input  logic [15:0]   mem_rdata_i,
    output logic [7:0]    byte_o,
    output logic          byte_vld_o,
    output logic [1:0]    qs_o
);
    import ifq_pkg::*;

    localparam int CW        = $clog2(DEPTH + 1);
    localparam int ROOM_FILL = DEPTH - 2;

    logic [CW-1:0] q_count;
    logic          pop_ok;
    logic          launch_ok;
    logic          deliver;
    logic [1:0]    deliver_n;
    logic [7:0]    lane0;
    qs_e           qs;

    assign pop_ok    = pop_i && (q_count != '0) && !flush_i;
    assign launch_ok = (q_count <= CW'(ROOM_FILL)) && !opnd_req_i;
    assign lane0     = mem_addr_o[0] ? mem_rdata_i[15:8] : mem_rdata_i[7:0];

    ifq_fetch #(.AW(AW)) u_fetch (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (flush_i),
        .flush_addr_i (flush_addr_i),
        .launch_ok_i  (launch_ok),
        .mem_ack_i    (mem_ack_i),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_two_o    (mem_two_o),
        .deliver_o    (deliver),
        .deliver_n_o  (deliver_n)
    );

    ifq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (flush_i),
        .pop_i     (pop_ok),
        .push_n_i  (deliver ? deliver_n : 2'd0),
        .push_b0_i (lane0),
        .push_b1_i (mem_rdata_i[15:8]),
        .head_o    (byte_o),
        .count_o   (q_count)
    );

    always_comb begin
        if (flush_i)     qs = QS_FLUSHED;
        else if (pop_ok) qs = pop_first_i ? QS_FIRST : QS_NEXT;
        else             qs = QS_IDLE;
    end

    assign qs_o       = qs;
    assign byte_vld_o = (q_count != '0);
    assign opnd_gnt_o = opnd_req_i && !mem_req_o;
endmodule

// File: rtl/ifq_ctrl_chk.sv
module ifq_ctrl_chk #(
    parameter int DEPTH = 6,
    parameter int AW    = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush_i,
    input logic          opnd_req_i,
    input logic          mem_req_o,
    input logic          mem_ack_i,
    input logic [AW-1:0] mem_addr_o,
    input logic [CW-1:0] q_count,
    input logic [1:0]    qs_o
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CW'(DEPTH)); // R1

    AST_LAUNCH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> ($past(q_count) <= CW'(DEPTH - 2)) && !$past(opnd_req_i)); // R2

    AST_OPND_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        opnd_req_i && !mem_req_o && !flush_i |=> !mem_req_o); // R4

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> q_count == '0); // R5

    AST_EMPTY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        q_count == '0 |-> qs_o != 2'b01 && qs_o != 2'b11); // R6

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o)); // R9

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o && mem_ack_i |=> !mem_req_o); // R9
endmodule

bind ifq_ctrl ifq_ctrl_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush_i    (flush_i),
    .opnd_req_i (opnd_req_i),
    .mem_req_o  (mem_req_o),
    .mem_ack_i  (mem_ack_i),
    .mem_addr_o (mem_addr_o),
    .q_count    (q_count),
    .qs_o       (qs_o)
);

// File: tb/ifq_ctrl_test.sv
module ifq_ctrl_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [15:0] addr;
        logic [3:0]  lat;
        logic [7:0]  npop;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{addr: 16'h0100, lat: 4'd0, npop: 8'd9},
        '{addr: 16'h0233, lat: 4'd2, npop: 8'd7},
        '{addr: 16'h1FFE, lat: 4'd1, npop: 8'd10},
        '{addr: 16'h4001, lat: 4'd5, npop: 8'd4},
        '{addr: 16'h00F0, lat: 4'd3, npop: 8'd12}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_i = 1'b0;
    logic [15:0] flush_addr_i = '0;
    logic        pop_i = 1'b0;
    logic        pop_first_i = 1'b0;
    logic        opnd_req_i = 1'b0;
    logic        opnd_gnt_o;
    logic        mem_req_o;
    logic [15:0] mem_addr_o;
    logic        mem_two_o;
    logic        mem_ack_i = 1'b0;
    logic [15:0] mem_rdata_i = '0;
    logic [7:0]  byte_o;
    logic        byte_vld_o;
    logic [1:0]  qs_o;

    int checks = 0;
    int errs = 0;
    int lat = 0;
    int wcnt = 0;
    logic [15:0] cap_addr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ifq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
        .pop_i(pop_i), .pop_first_i(pop_first_i), .opnd_req_i(opnd_req_i),
        .opnd_gnt_o(opnd_gnt_o), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_two_o(mem_two_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
        .byte_o(byte_o), .byte_vld_o(byte_vld_o), .qs_o(qs_o)
    );

    function automatic logic [7:0] mbyte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory responder: acknowledges after lat waiting cycles
    always @(negedge clk) begin
        if (mem_ack_i) begin
            mem_ack_i = 1'b0;
            wcnt = 0;
        end else if (rst_n && mem_req_o) begin
            if (wcnt == 0) cap_addr = mem_addr_o;
            if (wcnt >= lat) begin
                chk(mem_two_o == !mem_addr_o[0], "R3", "word/byte fetch by parity", int'(mem_two_o), int'(!mem_addr_o[0]));
                chk(mem_addr_o == cap_addr, "R9", "address held until ack", int'(mem_addr_o), int'(cap_addr));
                mem_rdata_i = {mbyte(mem_addr_o | 16'h1), mbyte(mem_addr_o & 16'hFFFE)};
                mem_ack_i = 1'b1;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic pop_one(input logic [7:0] exp, input bit first);
        bit stalled;
        stalled = 1'b0;
        pop_i = 1'b1;
        pop_first_i = first;
        #1;
        while (!byte_vld_o) begin
            if (!stalled) begin
                chk(qs_o == 2'b00, "R6", "status while stalled on empty", int'(qs_o), 0);
                stalled = 1'b1;
            end
            @(negedge clk);
            #1;
        end
        chk(byte_o == exp, "R1", "byte order", int'(byte_o), int'(exp));
        chk(qs_o == (first ? 2'b01 : 2'b11), "R7", "take status", int'(qs_o), first ? 1 : 3);
        @(negedge clk);
        pop_i = 1'b0;
    endtask

    task automatic flush_to(input logic [15:0] a, input bit with_pop);
        flush_i = 1'b1;
        flush_addr_i = a;
        pop_i = with_pop;
        pop_first_i = 1'b1;
        #1;
        chk(qs_o == 2'b10, "R7", "flush status", int'(qs_o), 2);
        @(negedge clk);
        flush_i = 1'b0;
        pop_i = 1'b0;
        #1;
        chk(!byte_vld_o, "R5", "queue empty after flush", int'(byte_vld_o), 0);
    endtask

    task automatic wait_req();
        while (!mem_req_o) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        // R10 reset state
        repeat (3) @(negedge clk);
        chk(!byte_vld_o, "R10", "empty in reset", int'(byte_vld_o), 0);
        chk(qs_o == 2'b00, "R10", "status in reset", int'(qs_o), 0);
        chk(!mem_req_o, "R10", "no request in reset", int'(mem_req_o), 0);
        rst_n = 1'b1;
        wait_req();
        chk(mem_addr_o == 16'h0000, "R10", "first fetch address", int'(mem_addr_o), 0);

        // table walk: R1 R3 R7 R8 across alignments and latencies
        foreach (VECS[i]) begin
            lat = int'(VECS[i].lat);
            flush_to(VECS[i].addr, 1'b0);
            for (int k = 0; k < int'(VECS[i].npop); k++)
                pop_one(mbyte(VECS[i].addr + 16'(k)), (k % 3) == 0);
        end

        // R2: full queue (even start) never fetches; 5 bytes still no fetch
        lat = 0;
        flush_to(16'h0300, 1'b0);
        repeat (30) @(negedge clk);
        #1 chk(!mem_req_o, "R2", "no fetch with 6 bytes", int'(mem_req_o), 0);
        pop_one(mbyte(16'h0300), 1'b1);
        begin
            bit seen;
            seen = 1'b0;
            repeat (8) begin @(negedge clk); #1 if (mem_req_o) seen = 1'b1; end
            chk(!seen, "R2", "no fetch with one free slot", int'(seen), 0);
            pop_one(mbyte(16'h0301), 1'b0);
            seen = 1'b0;
            repeat (4) begin #1 if (mem_req_o) seen = 1'b1; @(negedge clk); end
            chk(seen, "R2", "fetch after two slots free", int'(seen), 1);
        end
        for (int k = 2; k < 8; k++) pop_one(mbyte(16'h0300 + 16'(k)), 1'b0);

        // R2 R8: odd start fills to 5 and stops
        flush_to(16'h0401, 1'b0);
        repeat (30) @(negedge clk);
        #1 chk(!mem_req_o, "R2", "no fetch with 5 bytes", int'(mem_req_o), 0);
        for (int k = 0; k < 6; k++) pop_one(mbyte(16'h0401 + 16'(k)), k == 0);

        // R4: operand waits for fetch in flight, then blocks new fetches
        lat = 6;
        flush_to(16'h0500, 1'b0);
        wait_req();
        opnd_req_i = 1'b1;
        #1 chk(!opnd_gnt_o, "R4", "no grant during fetch", int'(opnd_gnt_o), 0);
        while (mem_req_o) begin @(negedge clk); #1; end
        chk(opnd_gnt_o, "R4", "grant after fetch", int'(opnd_gnt_o), 1);
        begin
            bit seen;
            seen = 1'b0;
            repeat (6) begin @(negedge clk); #1 if (mem_req_o) seen = 1'b1; end
            chk(!seen, "R4", "operand request blocks prefetch", int'(seen), 0);
        end
        @(negedge clk);
        opnd_req_i = 1'b0;
        for (int k = 0; k < 4; k++) pop_one(mbyte(16'h0500 + 16'(k)), k == 0);

        // R5: flush during a fetch in flight discards its data
        flush_to(16'h0600, 1'b0);
        wait_req();
        @(negedge clk);
        flush_to(16'h0700, 1'b0);
        for (int k = 0; k < 5; k++) pop_one(mbyte(16'h0700 + 16'(k)), k == 0);

        // R5 R7: flush wins over a pop in the same cycle
        lat = 1;
        repeat (20) @(negedge clk);
        flush_to(16'h0811, 1'b1);
        pop_one(mbyte(16'h0811), 1'b1);
        pop_one(mbyte(16'h0812), 1'b0);

        // R6: pop on empty stalls with long latency
        lat = 7;
        flush_to(16'h0900, 1'b0);
        pop_one(mbyte(16'h0900), 1'b1);
        pop_one(mbyte(16'h0901), 1'b0);

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule